// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block takes an SDR SDRAM from power-on to normal operation. A single start pulse launches a quiet period in which only NOP is driven on the command bus. After that it drives, for each populated rank, a precharge of all banks, eight auto-refresh commands and a load of the mode register. The mode word is built from the requested CAS latency. When the last rank has been programmed, the block raises a ready flag and keeps a periodic refresh timer running. From then on it signals each refresh that is due to the normal-mode scheduler.

The rank count, CAS latency and timing class are captured when start is accepted. The block also reports the access-timing spacings that the scheduler must respect afterwards. These come in two classes, normal and pessimistic. Reads and writes are not scheduled here.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While and right after reset, `cmd` is NOP (code 0), `ready` and `rfsh_req` are 0, `cs_idx` is 0 and `addr` is all zeros.
- R2: The first PRECHARGE-ALL appears exactly PWRUP_CLKS cycles after the clock edge that samples `start` high. Every cycle before it carries NOP (default PWRUP_CLKS is 12500, which is 100 µs at 125 MHz).
- R3: For each rank the commands come in the order PRECHARGE-ALL (code 1, with `addr` bit 10 high), eight AUTO-REFRESH (code 2), then MODE-REGISTER-SET (code 3). Each command lasts one cycle and NOP (code 0) fills every other cycle.
- R4: AUTO-REFRESH follows PRECHARGE-ALL by t_rp cycles. Consecutive AUTO-REFRESH commands, and the MODE-REGISTER-SET after the last one, are t_rfc cycles apart. With `slow_timing` = 0, t_rp is 3 and t_rfc is 7. With `slow_timing` = 1, t_rp is 8 and t_rfc is 16.
- R5: When `two_ranks` = 1, rank 0 is programmed first with `cs_idx` = 0. The PRECHARGE-ALL for rank 1 follows rank 0's MODE-REGISTER-SET by 2 cycles, and rank 1's whole sequence runs with `cs_idx` = 1. When `two_ranks` = 0, `cs_idx` stays 0.
- R6: During MODE-REGISTER-SET, `addr` holds these fields: bits 2:0 = 3'b010 (burst of 4), bit 3 = 0 (sequential), bits 6:4 = effective CAS latency, bit 9 = 0 (writes burst). All other bits are 0. A `cas_lat` value of 0 or 1 is raised to 2.
- R7: The timing outputs are t_rp = 3/8, t_rcd = 2/8 and t_rfc = 7/16 for normal/pessimistic timing. t_ldp (last data out to precharge) equals the effective CAS latency minus 1.
- R8: `ready` rises 2 cycles after the final MODE-REGISTER-SET and then stays high. It is low before that. While it is high, `cmd` is NOP.
- R9: `rfsh_req` is a one-cycle pulse, never given before `ready`. The first pulse comes (rfsh_reload+1)·PRESCALE_CLKS cycles after `ready` rises, and further pulses repeat at that same period.
- R10: Once a sequence has begun, `start` pulses are ignored. Changes on `two_ranks`, `cas_lat` or `slow_timing` do not alter the running sequence or the mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the power-up sequence (accepted only when idle) |
| two_ranks | input | 1 | 1: two chip selects populated, 0: one |
| cas_lat | input | 2 | Requested CAS latency |
| slow_timing | input | 1 | Selects the pessimistic timing class |
| rfsh_reload | input | RW (8) | Refresh interval in prescaler ticks, minus one |
| cmd | output | 2 | Command code: 0 NOP, 1 PRECHARGE-ALL, 2 AUTO-REFRESH, 3 MODE-REGISTER-SET |
| cs_idx | output | 1 | Chip select being driven |
| addr | output | ADDR_W (13) | Address bus (A10 during precharge, mode word during mode set) |
| ready | output | 1 | Initialization finished, normal mode entered |
| rfsh_req | output | 1 | A periodic refresh is due |
| t_rp | output | 5 | Precharge-to-activate spacing in clocks |
| t_rcd | output | 5 | Activate-to-read/write spacing in clocks |
| t_rfc | output | 5 | Refresh recovery in clocks |
| t_ldp | output | 5 | Last-data-out-to-precharge spacing in clocks |

## Verification
A spacing counter that reloads wrongly moves every later command. The error then shows at the next non-NOP cycle, a few clocks after the fault. A wrong refresh count shifts the mode-register load by a whole t_rfc and delays `ready` by the same amount. A wrong rank flag shows either as a missing second sequence on `cs_idx` = 1 or as an extra one, about 60 to 150 cycles later. Errors in the prescaler or the reload counter are visible only through when `rfsh_req` occurs, so the bench measures the first two refresh periods exactly.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PREA = 2'd1,
        CMD_REF  = 2'd2,
        CMD_MRS  = 2'd3
    } sd_cmd_e;

    typedef struct packed {
        logic       two;
        logic [1:0] cl;
        logic       slow;
    } init_cfg_t;

    typedef struct packed {
        logic [4:0] rp;
        logic [4:0] rcd;
        logic [4:0] rfc;
        logic [4:0] ldp;
    } timing_t;

    localparam int REF_COUNT = 8;
    localparam int MRD_CLKS  = 2;
    localparam int AP_BIT    = 10;
    localparam int MODE_W    = 12;

    function automatic logic [2:0] eff_cl(logic [1:0] cl);
        return (cl < 2'd2) ? 3'd2 : {1'b0, cl};
    endfunction

    function automatic timing_t timing_of(init_cfg_t c);
        timing_t t;
        t.rp  = c.slow ? 5'd8  : 5'd3;
        t.rcd = c.slow ? 5'd8  : 5'd2;
        t.rfc = c.slow ? 5'd16 : 5'd7;
        t.ldp = {2'b00, eff_cl(c.cl)} - 5'd1;
        return t;
    endfunction

    function automatic logic [MODE_W-1:0] mode_word(logic [2:0] cl);
        logic [MODE_W-1:0] m;
        m      = '0;
        m[2:0] = 3'b010;   // burst of four
        m[3]   = 1'b0;     // sequential ordering
        m[6:4] = cl;
        m[9]   = 1'b0;     // writes follow the burst length
        return m;
    endfunction

endpackage

// File: rtl/sdram_rfsh_timer.sv
module sdram_rfsh_timer #(
    parameter int PRESCALE_CLKS = 125,
    parameter int RW            = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [RW-1:0] reload,
    output logic          req_o
);
    localparam int PW = (PRESCALE_CLKS > 2) ? $clog2(PRESCALE_CLKS) : 1;

    logic [PW-1:0] pre_q;
    logic [RW-1:0] tick_q;
    logic          tick;

    assign tick = en && (pre_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pre_q  <= PW'(PRESCALE_CLKS - 1);
            tick_q <= reload;
            req_o  <= 1'b0;
        end else begin
            req_o <= 1'b0;
            pre_q <= tick ? PW'(PRESCALE_CLKS - 1) : pre_q - 1'b1;
            if (tick) begin
                if (tick_q == '0) begin
                    tick_q <= reload;
                    req_o  <= 1'b1;
                end else begin
                    tick_q <= tick_q - 1'b1;
                end
            end
        end
    end

    AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        req_o |-> en);                                   // R9
    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);                               // R9

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int PWRUP_CLKS = 12500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  init_cfg_t         cfg_in,
    output sd_cmd_e           cmd_o,
    output logic              cs_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ready_o,
    output timing_t           tim_o
);
    localparam int PW_BITS = $clog2(PWRUP_CLKS + 1);
    localparam int CW      = (PW_BITS > 5) ? PW_BITS : 5;
    localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} state_e;
    typedef enum logic [1:0] {N_PRE, N_REF, N_MRS, N_DONE} next_e;

    state_e    state_q;
    next_e     nxt_q;
    init_cfg_t cfg_q;
    logic [CW-1:0] gap_q;
    logic [3:0]    refs_q;
    logic          second_q;
    timing_t       tim;

    assign tim   = timing_of(cfg_q);
    assign tim_o = tim;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            nxt_q    <= N_PRE;
            cfg_q    <= '0;
            gap_q    <= '0;
            refs_q   <= '0;
            second_q <= 1'b0;
            cmd_o    <= CMD_NOP;
            cs_o     <= 1'b0;
            addr_o   <= '0;
            ready_o  <= 1'b0;
        end else begin
            cmd_o  <= CMD_NOP;
            addr_o <= '0;
            case (state_q)
                ST_IDLE: if (start) begin
                    cfg_q    <= cfg_in;
                    state_q  <= ST_WAIT;
                    gap_q    <= CW'(PWRUP_CLKS - 1);
                    nxt_q    <= N_PRE;
                    second_q <= 1'b0;
                end
                ST_WAIT: if (gap_q != '0) begin
                    gap_q <= gap_q - 1'b1;
                end else begin
                    case (nxt_q)
                        N_PRE: begin
                            cmd_o  <= CMD_PREA;
                            addr_o <= AP_MASK;
                            cs_o   <= second_q;
                            gap_q  <= CW'(tim.rp) - CW'(1);
                            refs_q <= 4'(REF_COUNT);
                            nxt_q  <= N_REF;
                        end
                        N_REF: begin
                            cmd_o  <= CMD_REF;
                            refs_q <= refs_q - 1'b1;
                            gap_q  <= CW'(tim.rfc) - CW'(1);
                            nxt_q  <= (refs_q == 4'd1) ? N_MRS : N_REF;
                        end
                        N_MRS: begin
                            cmd_o  <= CMD_MRS;
                            addr_o <= ADDR_W'(mode_word(eff_cl(cfg_q.cl)));
                            gap_q  <= CW'(MRD_CLKS - 1);
                            if (cfg_q.two && !second_q) begin
                                second_q <= 1'b1;
                                nxt_q    <= N_PRE;
                            end else begin
                                nxt_q    <= N_DONE;
                            end
                        end
                        default: begin
                            state_q <= ST_RUN;
                            ready_o <= 1'b1;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    AST_ONE_CYCLE_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != CMD_NOP) |=> (cmd_o == CMD_NOP));      // R3
    AST_PREA_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_PREA) |-> addr_o[AP_BIT]);         // R3
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> ready_o);                            // R8
    AST_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (cmd_o == CMD_NOP));                 // R8
    AST_SECOND_RANK_ONLY: assert property (@(posedge clk) disable iff (rst)
        cs_o |-> cfg_q.two);                             // R5

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int PWRUP_CLKS    = 12500,
    parameter int PRESCALE_CLKS = 125,
    parameter int RW            = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              two_ranks,
    input  logic [1:0]        cas_lat,
    input  logic              slow_timing,
    input  logic [RW-1:0]     rfsh_reload,
    output logic [1:0]        cmd,
    output logic              cs_idx,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              rfsh_req,
    output logic [4:0]        t_rp,
    output logic [4:0]        t_rcd,
    output logic [4:0]        t_rfc,
    output logic [4:0]        t_ldp
);
    init_cfg_t cfg_in;
    sd_cmd_e   cmd_e;
    timing_t   tim;

    assign cfg_in = '{two: two_ranks, cl: cas_lat, slow: slow_timing};
    assign cmd    = cmd_e;
    assign t_rp   = tim.rp;
    assign t_rcd  = tim.rcd;
    assign t_rfc  = tim.rfc;
    assign t_ldp  = tim.ldp;

    sdram_init_fsm #(
        .ADDR_W     (ADDR_W),
        .PWRUP_CLKS (PWRUP_CLKS)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cfg_in  (cfg_in),
        .cmd_o   (cmd_e),
        .cs_o    (cs_idx),
        .addr_o  (addr),
        .ready_o (ready),
        .tim_o   (tim)
    );

    sdram_rfsh_timer #(
        .PRESCALE_CLKS (PRESCALE_CLKS),
        .RW            (RW)
    ) u_rfsh (
        .clk    (clk),
        .rst    (rst),
        .en     (ready),
        .reload (rfsh_reload),
        .req_o  (rfsh_req)
    );

    initial begin
        AST_ADDR_HOLDS_A10: assert (ADDR_W > AP_BIT);    // R3
    end

endmodule

// File: tb/tb_sdram_powerup_seq.sv
module tb_sdram_powerup_seq;
    localparam int AW  = 13;
    localparam int PWR = 250;
    localparam int PRE = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic two_ranks = 1'b0;
    logic [1:0] cas_lat = 2'd2;
    logic slow_timing = 1'b0;
    logic [7:0] rfsh_reload = 8'd0;
    logic [1:0] cmd;
    logic cs_idx;
    logic [AW-1:0] addr;
    logic ready, rfsh_req;
    logic [4:0] t_rp, t_rcd, t_rfc, t_ldp;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sdram_powerup_seq #(.ADDR_W(AW), .PWRUP_CLKS(PWR), .PRESCALE_CLKS(PRE), .RW(8)) dut (
        .clk(clk), .rst(rst), .start(start), .two_ranks(two_ranks), .cas_lat(cas_lat),
        .slow_timing(slow_timing), .rfsh_reload(rfsh_reload), .cmd(cmd), .cs_idx(cs_idx),
        .addr(addr), .ready(ready), .rfsh_req(rfsh_req), .t_rp(t_rp), .t_rcd(t_rcd),
        .t_rfc(t_rfc), .t_ldp(t_ldp)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cl_of(input logic [1:0] cl);
        return (cl < 2) ? 2 : int'(cl);
    endfunction

    function automatic int mode_of(input logic [1:0] cl);
        return 2 + (cl_of(cl) << 4);
    endfunction

    task automatic run_seq(input bit two, input logic [1:0] cl, input bit slow,
                           input int reload, input bit disturb);
        int ev_t[20];
        int ev_k[20];
        int ev_cs[20];
        int nev, t, rdy_t, idx, stray, reqbad, period, rp, rfc, last;
        rp = slow ? 8 : 3;
        rfc = slow ? 16 : 7;
        period = (reload + 1) * PRE;
        @(negedge clk);
        rst = 1'b1; start = 1'b0;
        two_ranks = two; cas_lat = cl; slow_timing = slow; rfsh_reload = 8'(reload);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(cmd == 0 && ready == 0 && rfsh_req == 0 && cs_idx == 0 && addr == 0,
            "R1", "reset outputs", {cmd, ready, rfsh_req, cs_idx}, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // expected schedule, cycle 0 = first sample after the start edge
        nev = 0; t = PWR;
        for (int d = 0; d < (two ? 2 : 1); d++) begin
            ev_t[nev] = t; ev_k[nev] = 1; ev_cs[nev] = d; nev++; t += rp;
            for (int r = 0; r < 8; r++) begin
                ev_t[nev] = t; ev_k[nev] = 2; ev_cs[nev] = d; nev++; t += rfc;
            end
            ev_t[nev] = t - rfc + rfc; ev_k[nev] = 3; ev_cs[nev] = d; nev++; t += 2;
        end
        rdy_t = t;
        last = rdy_t + 2 * period + 2;
        idx = 0; stray = 0; reqbad = 0;
        for (int c = 0; c <= last; c++) begin
            if (c > 0) @(negedge clk);
            if (idx < nev && c == ev_t[idx]) begin
                chk(int'(cmd) == ev_k[idx], (idx == 0) ? "R2" : "R4", "command at scheduled cycle",
                    int'(cmd), ev_k[idx]);
                chk(int'(cs_idx) == ev_cs[idx], "R5", "chip select", int'(cs_idx), ev_cs[idx]);
                if (ev_k[idx] == 1)
                    chk(addr[10] == 1'b1, "R3", "precharge A10", int'(addr[10]), 1);
                if (ev_k[idx] == 3)
                    chk(int'(addr) == mode_of(cl), "R6", "mode word", int'(addr), mode_of(cl));
                idx++;
            end else if (cmd != 0) begin
                stray++;
            end
            if (c == rdy_t - 1) chk(ready == 0, "R8", "ready early", int'(ready), 0);
            if (c == rdy_t) begin
                chk(ready == 1, "R8", "ready rise", int'(ready), 1);
                chk(int'(t_rp) == rp, "R7", "t_rp", int'(t_rp), rp);
                chk(int'(t_rcd) == (slow ? 8 : 2), "R7", "t_rcd", int'(t_rcd), slow ? 8 : 2);
                chk(int'(t_rfc) == rfc, "R7", "t_rfc", int'(t_rfc), rfc);
                chk(int'(t_ldp) == cl_of(cl) - 1, "R7", "t_ldp", int'(t_ldp), cl_of(cl) - 1);
            end
            if (c == rdy_t + period)
                chk(rfsh_req == 1, "R9", "first refresh request", int'(rfsh_req), 1);
            else if (c == rdy_t + 2 * period)
                chk(rfsh_req == 1, "R9", "second refresh request", int'(rfsh_req), 1);
            else if (rfsh_req != 0)
                reqbad++;
            if (c > rdy_t && ready != 1) stray++;
            if (disturb && c == 40) begin
                start = 1'b1; two_ranks = !two; cas_lat = cl ^ 2'b01; slow_timing = !slow;
            end
            if (disturb && c == 41) start = 1'b0;
        end
        chk(stray == 0, "R3", "stray commands or ready drop", stray, 0);
        chk(idx == nev, "R3", "commands seen", idx, nev);
        chk(reqbad == 0, "R9", "stray refresh requests", reqbad, 0);
        if (disturb)
            chk(stray == 0 && idx == nev, "R10", "sequence disturbed by later inputs", stray, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        run_seq(1'b0, 2'd2, 1'b0, 0, 1'b0);
        run_seq(1'b1, 2'd3, 1'b1, 1, 1'b1);
        run_seq(1'b0, 2'd1, 1'b0, 2, 1'b0);
        run_seq(1'b1, 2'd0, 1'b0, 3, 1'b1);
        for (int k = 0; k < 4; k++)
            run_seq(1'($urandom), 2'($urandom), 1'($urandom), int'($urandom % 4), 1'($urandom));
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule